// File: doc/BRIEF.md
# USB 2.0 High-Speed Transmit Slew-Rate Calibration Sequencer

This controller trims the transmit edge rate of a high-speed USB 2.0 port in hardware. After a start pulse it enables the port's ring oscillator and waits for it to settle. It then drives a shared frequency meter through a small register port. The meter gets its free-running clock, a fixed 1024-cycle measurement window on the port's channel, and an enable. The controller polls the meter for a valid flag and reads the count. It shuts the meter down again and turns the count into a 3-bit slew code.

The code is computed on chip. A restoring divider first forms the truncated quotient of 1024 x 26 x 28 by the measured count. A second pass through the same divider gives the rounded quotient of that result by 1000. A count of zero selects a default code of 4. The code is written to the slew output, and only after that is the oscillator released and done pulsed. All delays come from a microsecond tick divided down from the 26 MHz reference clock that also clocks the block.

The meter sits behind three word registers. Address 0 is control: bit 0 is the meter enable, bits 2:1 select the channel, and bits 31:8 hold the window length. Address 1 is auxiliary: bit 0 is the free-run clock enable when written, and bit 4 is the valid flag when read. Address 2 returns the count in bits 23:0. Read data is taken on the cycle after the read request.

Top module: `srcal_seq`

## Requirements
- R1: Out of reset the slew code is 4, the oscillator enable and done are low, and no meter request is made while the oscillator enable is low.
- R2: A start seen while idle raises the oscillator enable on the next cycle and reloads the slew code with 4. The first meter access comes at least 26 cycles (one microsecond) after the oscillator enable rises.
- R3: The meter is configured by three writes in this order: address 1 with bit 0 set, then address 0 with the window 1024 in bits 31:8, the start channel in bits 2:1 and bit 0 clear, then the same word with bit 0 set.
- R4: Address 1 is then read, and bit 4 of the returned word is the valid flag. Reads repeat no closer than 260 cycles (10 us) apart and stop at the first read that returns valid.
- R5: If 21 reads (one initial read and 20 retries, 200 us) all return no valid flag, the count is read anyway.
- R6: After the count at address 2 is read, the meter is shut down by writing address 0 with bit 0 clear, then writing 0 to address 1.
- R7: For a nonzero count C the code is the low 3 bits of ((745472 / C) + 500) / 1000, with both divisions truncating.
- R8: A count of zero yields the code 4.
- R9: The slew code is updated while the oscillator enable is still high. The oscillator enable falls one cycle later, and done is a one-cycle pulse with the oscillator enable low.
- R10: A start that arrives while a calibration is running is ignored. The run keeps its channel and ends with a single done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 26 MHz reference clock |
| rst_n | input | 1 | asynchronous active-low reset |
| start_i | input | 1 | begin a calibration (taken while idle) |
| chan_i | input | 2 | meter channel of the port, captured at start |
| done_o | output | 1 | one-cycle pulse at the end of a calibration |
| osc_en_o | output | 1 | ring oscillator enable |
| slew_code_o | output | 3 | transmit slew-rate code |
| mtr_req_o | output | 1 | meter register access request |
| mtr_we_o | output | 1 | access is a write |
| mtr_addr_o | output | 2 | meter register address |
| mtr_wdata_o | output | 32 | meter write data |
| mtr_rdata_i | input | 32 | meter read data, valid the cycle after a read request |

## Verification
Meter accesses are due at fixed distances from the rise of the oscillator enable. The first write comes at least 26 cycles after it. Each poll read comes at least 260 cycles after the previous one, and the count read follows the first valid read, or the 21st read, by two cycles. The scoreboard compares every request on the falling edge of the cycle in which it is presented, so each access is checked in the cycle it is due. The code is compared on the falling edge where done is high, and on the edge before it the code must already hold its new value with the oscillator still enabled.

// File: rtl/srcal_pkg.sv
package srcal_pkg;

  typedef enum logic [4:0] {
    S_IDLE,
    S_SETTLE,
    S_WR_FRC,
    S_WR_CFG,
    S_WR_EN,
    S_POLL_RD,
    S_POLL_CHK,
    S_POLL_WAIT,
    S_CNT_RD,
    S_CNT_CAP,
    S_WR_DIS,
    S_WR_FRC_OFF,
    S_CALC,
    S_CALC_WAIT,
    S_WR_CODE,
    S_CODE_HOLD,
    S_DONE
  } seq_state_e;

  typedef enum logic [1:0] {
    C_IDLE,
    C_DIV1,
    C_DIV2
  } calc_state_e;

  // meter register map
  localparam logic [1:0] MTR_CTRL = 2'd0;
  localparam logic [1:0] MTR_AUX  = 2'd1;
  localparam logic [1:0] MTR_CNT  = 2'd2;

  localparam int CTRL_EN_BIT   = 0;
  localparam int CTRL_CH_LSB   = 1;
  localparam int CTRL_WIN_LSB  = 8;
  localparam int AUX_FRC_BIT   = 0;
  localparam int AUX_VALID_BIT = 4;

endpackage

// File: rtl/srcal_tick.sv
module srcal_tick #(
  parameter int REF_MHZ = 26
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  output logic tick_o
);
  localparam int PW = (REF_MHZ > 1) ? $clog2(REF_MHZ) : 1;
  localparam logic [PW-1:0] LAST = PW'(REF_MHZ - 1);

  logic [PW-1:0] cnt_q, cnt_d;

  assign tick_o = (cnt_q == LAST);

  always_comb begin
    if (clr_i || tick_o) cnt_d = '0;
    else                 cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/srcal_div.sv
module srcal_div #(
  parameter int NW = 20,
  parameter int DW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [NW-1:0] dividend_i,
  input  logic [DW-1:0] divisor_i,
  output logic          done_o,
  output logic [NW-1:0] quo_o
);
  localparam int CW = $clog2(NW + 1);

  logic [DW-1:0] rem_q, rem_d;
  logic [NW-1:0] quo_q, quo_d;
  logic [DW-1:0] dvs_q;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          run_q, run_d;
  logic          done_q, done_d;
  logic [DW:0]   trial;
  logic          fits;

  assign trial = {rem_q, quo_q[NW-1]};
  assign fits  = (trial >= {1'b0, dvs_q});

  always_comb begin
    rem_d  = rem_q;
    quo_d  = quo_q;
    cnt_d  = cnt_q;
    run_d  = run_q;
    done_d = 1'b0;
    if (start_i && !run_q) begin
      rem_d = '0;
      quo_d = dividend_i;
      cnt_d = CW'(NW);
      run_d = 1'b1;
    end else if (run_q) begin
      if (fits) rem_d = DW'(trial - {1'b0, dvs_q});
      else      rem_d = trial[DW-1:0];
      quo_d = {quo_q[NW-2:0], fits};
      cnt_d = cnt_q - 1'b1;
      if (cnt_q == CW'(1)) begin
        run_d  = 1'b0;
        done_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      quo_q  <= '0;
      cnt_q  <= '0;
      run_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      rem_q  <= rem_d;
      quo_q  <= quo_d;
      cnt_q  <= cnt_d;
      run_q  <= run_d;
      done_q <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  dvs_q <= '0;
    else if (start_i && !run_q)  dvs_q <= divisor_i;
  end

  assign done_o = done_q;
  assign quo_o  = quo_q;
endmodule

// File: rtl/srcal_calc.sv
module srcal_calc import srcal_pkg::*; #(
  parameter int CNT_W        = 24,
  parameter int WINDOW       = 1024,
  parameter int REF_MHZ      = 26,
  parameter int SR_COEF      = 28,
  parameter int SR_DIV       = 1000,
  parameter int DEFAULT_CODE = 4,
  parameter int CODE_W       = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [CNT_W-1:0]  count_i,
  output logic              done_o,
  output logic [CODE_W-1:0] code_o
);
  localparam int NUM  = WINDOW * REF_MHZ * SR_COEF;
  localparam int HALF = SR_DIV / 2;
  localparam int NW   = $clog2(NUM + HALF + 1);
  localparam logic [NW-1:0]     NUM_V  = NW'(NUM);
  localparam logic [NW-1:0]     HALF_V = NW'(HALF);
  localparam logic [CNT_W-1:0]  SRD_V  = CNT_W'(SR_DIV);
  localparam logic [CODE_W-1:0] DEF_V  = CODE_W'(DEFAULT_CODE);

  calc_state_e        st_q, st_d;
  logic               div_start, div_done;
  logic [NW-1:0]      div_num, div_quo;
  logic [CNT_W-1:0]   div_dvs;
  logic [CODE_W-1:0]  code_q, code_d;
  logic               done_q, done_d;

  // first pass: window constant over count; second pass: rounding by SR_DIV
  always_comb begin
    if (st_q == C_DIV1) begin
      div_num = div_quo + HALF_V;
      div_dvs = SRD_V;
    end else begin
      div_num = NUM_V;
      div_dvs = count_i;
    end
  end

  always_comb begin
    st_d      = st_q;
    code_d    = code_q;
    done_d    = 1'b0;
    div_start = 1'b0;
    case (st_q)
      C_IDLE: if (start_i) begin
        if (count_i == '0) begin
          code_d = DEF_V;
          done_d = 1'b1;
        end else begin
          div_start = 1'b1;
          st_d      = C_DIV1;
        end
      end
      C_DIV1: if (div_done) begin
        div_start = 1'b1;
        st_d      = C_DIV2;
      end
      C_DIV2: if (div_done) begin
        code_d = div_quo[CODE_W-1:0];
        done_d = 1'b1;
        st_d   = C_IDLE;
      end
      default: st_d = C_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= C_IDLE;
      code_q <= DEF_V;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      code_q <= code_d;
      done_q <= done_d;
    end
  end

  srcal_div #(.NW(NW), .DW(CNT_W)) i_div (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (div_start),
    .dividend_i (div_num),
    .divisor_i  (div_dvs),
    .done_o     (div_done),
    .quo_o      (div_quo)
  );

  assign done_o = done_q;
  assign code_o = code_q;
endmodule

// File: rtl/srcal_seq.sv
module srcal_seq import srcal_pkg::*; #(
  parameter int CH_W         = 2,
  parameter int REF_MHZ      = 26,
  parameter int SETTLE_US    = 1,
  parameter int POLL_US      = 10,
  parameter int POLL_MAX     = 20,
  parameter int WINDOW       = 1024,
  parameter int CNT_W        = 24,
  parameter int SR_COEF      = 28,
  parameter int SR_DIV       = 1000,
  parameter int DEFAULT_CODE = 4,
  parameter int CODE_W       = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [CH_W-1:0]   chan_i,
  output logic              done_o,
  output logic              osc_en_o,
  output logic [CODE_W-1:0] slew_code_o,
  output logic              mtr_req_o,
  output logic              mtr_we_o,
  output logic [1:0]        mtr_addr_o,
  output logic [31:0]       mtr_wdata_o,
  input  logic [31:0]       mtr_rdata_i
);
  localparam int WAIT_MAX = (SETTLE_US > POLL_US) ? SETTLE_US : POLL_US;
  localparam int WAIT_W   = $clog2(WAIT_MAX + 1);
  localparam int PC_W     = $clog2(POLL_MAX + 1);
  localparam logic [CODE_W-1:0] DEF_V = CODE_W'(DEFAULT_CODE);
  localparam logic [31:0] WIN_WORD = 32'(WINDOW) << CTRL_WIN_LSB;

  logic               rst_meta_q, rst_sync_n;
  seq_state_e         state_q, state_d;
  logic [CH_W-1:0]    chan_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [CODE_W-1:0]  slew_q;
  logic [WAIT_W-1:0]  wait_q;
  logic [PC_W-1:0]    polls_q;
  logic               tick, st_chg, wait_done, meter_valid;
  logic               calc_start, calc_done;
  logic [CODE_W-1:0]  calc_code;
  logic [WAIT_W-1:0]  wait_last;
  logic [31:0]        ctrl_base;

  // reset: asserted asynchronously, released on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  assign st_chg      = (state_d != state_q);
  assign meter_valid = mtr_rdata_i[AUX_VALID_BIT];
  assign wait_last   = (state_q == S_SETTLE) ? WAIT_W'(SETTLE_US - 1) : WAIT_W'(POLL_US - 1);
  assign wait_done   = tick && (wait_q == wait_last);
  assign calc_start  = (state_q == S_CALC);

  // next-state logic
  always_comb begin
    state_d = state_q;
    case (state_q)
      S_IDLE:       if (start_i) state_d = S_SETTLE;
      S_SETTLE:     if (wait_done) state_d = S_WR_FRC;
      S_WR_FRC:     state_d = S_WR_CFG;
      S_WR_CFG:     state_d = S_WR_EN;
      S_WR_EN:      state_d = S_POLL_RD;
      S_POLL_RD:    state_d = S_POLL_CHK;
      S_POLL_CHK: begin
        if (meter_valid || polls_q == PC_W'(POLL_MAX)) state_d = S_CNT_RD;
        else                                          state_d = S_POLL_WAIT;
      end
      S_POLL_WAIT:  if (wait_done) state_d = S_POLL_RD;
      S_CNT_RD:     state_d = S_CNT_CAP;
      S_CNT_CAP:    state_d = S_WR_DIS;
      S_WR_DIS:     state_d = S_WR_FRC_OFF;
      S_WR_FRC_OFF: state_d = S_CALC;
      S_CALC:       state_d = S_CALC_WAIT;
      S_CALC_WAIT:  if (calc_done) state_d = S_WR_CODE;
      S_WR_CODE:    state_d = S_CODE_HOLD;
      S_CODE_HOLD:  state_d = S_DONE;
      S_DONE:       state_d = S_IDLE;
      default:      state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) state_q <= S_IDLE;
    else             state_q <= state_d;
  end

  // microsecond wait counter, restarted on every state change
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  wait_q <= '0;
    else if (st_chg)  wait_q <= '0;
    else if (tick)    wait_q <= wait_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)
      polls_q <= '0;
    else if (state_q == S_IDLE)
      polls_q <= '0;
    else if (state_q == S_POLL_CHK && state_d == S_POLL_WAIT)
      polls_q <= polls_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)                        chan_q <= '0;
    else if (state_q == S_IDLE && start_i)  chan_q <= chan_i;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)                cnt_q <= '0;
    else if (state_q == S_CNT_CAP)  cnt_q <= mtr_rdata_i[CNT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)                        slew_q <= DEF_V;
    else if (state_q == S_IDLE && start_i)  slew_q <= DEF_V;
    else if (state_q == S_WR_CODE)          slew_q <= calc_code;
  end

  // meter register port
  assign ctrl_base = WIN_WORD | (32'(chan_q) << CTRL_CH_LSB);

  always_comb begin
    mtr_req_o   = 1'b0;
    mtr_we_o    = 1'b0;
    mtr_addr_o  = MTR_CTRL;
    mtr_wdata_o = '0;
    case (state_q)
      S_WR_FRC: begin
        mtr_req_o   = 1'b1;
        mtr_we_o    = 1'b1;
        mtr_addr_o  = MTR_AUX;
        mtr_wdata_o = 32'd1 << AUX_FRC_BIT;
      end
      S_WR_CFG, S_WR_DIS: begin
        mtr_req_o   = 1'b1;
        mtr_we_o    = 1'b1;
        mtr_addr_o  = MTR_CTRL;
        mtr_wdata_o = ctrl_base;
      end
      S_WR_EN: begin
        mtr_req_o   = 1'b1;
        mtr_we_o    = 1'b1;
        mtr_addr_o  = MTR_CTRL;
        mtr_wdata_o = ctrl_base | (32'd1 << CTRL_EN_BIT);
      end
      S_POLL_RD: begin
        mtr_req_o  = 1'b1;
        mtr_addr_o = MTR_AUX;
      end
      S_CNT_RD: begin
        mtr_req_o  = 1'b1;
        mtr_addr_o = MTR_CNT;
      end
      S_WR_FRC_OFF: begin
        mtr_req_o   = 1'b1;
        mtr_we_o    = 1'b1;
        mtr_addr_o  = MTR_AUX;
      end
      default: ;
    endcase
  end

  assign osc_en_o    = (state_q != S_IDLE) && (state_q != S_DONE);
  assign done_o      = (state_q == S_DONE);
  assign slew_code_o = slew_q;

  srcal_tick #(.REF_MHZ(REF_MHZ)) i_tick (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .clr_i  (st_chg),
    .tick_o (tick)
  );

  srcal_calc #(
    .CNT_W(CNT_W), .WINDOW(WINDOW), .REF_MHZ(REF_MHZ), .SR_COEF(SR_COEF),
    .SR_DIV(SR_DIV), .DEFAULT_CODE(DEFAULT_CODE), .CODE_W(CODE_W)
  ) i_calc (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .start_i (calc_start),
    .count_i (cnt_q),
    .done_o  (calc_done),
    .code_o  (calc_code)
  );
endmodule

// File: rtl/srcal_chk.sv
module srcal_chk #(
  parameter int CODE_W = 3,
  parameter int WINDOW = 1024
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic              done_o,
  input logic              osc_en_o,
  input logic [CODE_W-1:0] slew_code_o,
  input logic              mtr_req_o,
  input logic              mtr_we_o,
  input logic [1:0]        mtr_addr_o,
  input logic [31:0]       mtr_wdata_o
);
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !osc_en_o |-> !mtr_req_o);

  assert_osc_from_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(osc_en_o) |-> $past(start_i));

  assert_window_word_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mtr_req_o && mtr_we_o && mtr_addr_o == 2'd0) |-> (mtr_wdata_o[31:8] == 24'(WINDOW)));

  assert_code_under_osc_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(slew_code_o) |-> osc_en_o);

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_done_osc_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!osc_en_o && $past(osc_en_o)));
endmodule

bind srcal_seq srcal_chk #(.CODE_W(CODE_W), .WINDOW(WINDOW)) i_srcal_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .done_o      (done_o),
  .osc_en_o    (osc_en_o),
  .slew_code_o (slew_code_o),
  .mtr_req_o   (mtr_req_o),
  .mtr_we_o    (mtr_we_o),
  .mtr_addr_o  (mtr_addr_o),
  .mtr_wdata_o (mtr_wdata_o)
);

// File: tb/test_srcal_seq.sv
`timescale 1ns/1ps
module test_srcal_seq;
  localparam int SETTLE_CYC = 26;
  localparam int POLL_CYC   = 260;
  localparam int MAX_READS  = 21;

  typedef struct packed {
    logic        we;
    logic [1:0]  addr;
    logic [31:0] data;
  } acc_t;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i;
  logic [1:0]  chan_i;
  logic        done_o, osc_en_o;
  logic [2:0]  slew_code_o;
  logic        mtr_req_o, mtr_we_o;
  logic [1:0]  mtr_addr_o;
  logic [31:0] mtr_wdata_o, mtr_rdata_i;

  int checks = 0, fails = 0;
  int cyc = 0;
  acc_t exp_q[$];
  int exp_code_v;
  int cnt_val, valid_at;
  int aux_rd_n;
  logic [31:0] rd_q;
  int done_seen;
  int osc_rise_cyc, last_aux_cyc, first_acc;
  logic prev_osc;
  logic [2:0] prev_code;

  always #4 clk = ~clk;

  srcal_seq i_srcal_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .chan_i(chan_i),
    .done_o(done_o), .osc_en_o(osc_en_o), .slew_code_o(slew_code_o),
    .mtr_req_o(mtr_req_o), .mtr_we_o(mtr_we_o), .mtr_addr_o(mtr_addr_o),
    .mtr_wdata_o(mtr_wdata_o), .mtr_rdata_i(mtr_rdata_i)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // frequency meter model
  assign mtr_rdata_i = rd_q;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (start_i && !osc_en_o) aux_rd_n <= 0;
    else if (mtr_req_o && !mtr_we_o) begin
      if (mtr_addr_o == 2'd1) begin
        aux_rd_n <= aux_rd_n + 1;
        rd_q <= (valid_at != 0 && aux_rd_n + 1 >= valid_at) ? (32'd1 << 4) : 32'd0;
      end else if (mtr_addr_o == 2'd2) rd_q <= 32'(cnt_val);
      else rd_q <= 32'd0;
    end
  end

  // monitor: scoreboard of meter accesses and code at done
  always @(negedge clk) begin
    if (rst_n) begin
      if (osc_en_o && !prev_osc) begin
        osc_rise_cyc = cyc;
        first_acc = 1;
        last_aux_cyc = -1;
      end
      if (mtr_req_o) begin
        if (first_acc == 1) begin
          check(cyc - osc_rise_cyc >= SETTLE_CYC, "R2", "settle gap", cyc - osc_rise_cyc, SETTLE_CYC);
          first_acc = 0;
        end
        if (!mtr_we_o && mtr_addr_o == 2'd1) begin
          if (last_aux_cyc >= 0)
            check(cyc - last_aux_cyc >= POLL_CYC, "R4", "poll interval", cyc - last_aux_cyc, POLL_CYC);
          last_aux_cyc = cyc;
        end
        if (exp_q.size() == 0) begin
          check(0, "R4", "unexpected meter access addr", mtr_addr_o, 0);
        end else begin
          acc_t e;
          e = exp_q.pop_front();
          check(mtr_we_o == e.we && mtr_addr_o == e.addr, "R3",
                "access kind {we,addr}", {mtr_we_o, mtr_addr_o}, {e.we, e.addr});
          if (e.we)
            check(mtr_wdata_o == e.data, "R6", "write data", mtr_wdata_o, e.data);
        end
      end
      if (done_o) begin
        done_seen++;
        check(slew_code_o == 3'(exp_code_v), "R7", "slew code", slew_code_o, exp_code_v);
        check(prev_code == 3'(exp_code_v) && prev_osc, "R9", "code set before osc off",
              {prev_osc, prev_code}, {1'b1, 3'(exp_code_v)});
        check(!osc_en_o, "R9", "osc low at done", osc_en_o, 0);
        check(exp_q.size() == 0, "R6", "accesses outstanding", exp_q.size(), 0);
      end
    end
    prev_osc = osc_en_o;
    prev_code = slew_code_o;
  end

  function automatic int model_code(input int c);
    int q;
    if (c == 0) return 4;
    q = 745472 / c;
    return ((q + 500) / 1000) % 8;
  endfunction

  function automatic acc_t mk(input logic we, input logic [1:0] a, input logic [31:0] d);
    acc_t x;
    x.we = we; x.addr = a; x.data = d;
    return x;
  endfunction

  task automatic run_cal(input int ch, input int count, input int vat, input bit busy_start);
    int reads, t0;
    logic [31:0] base;
    cnt_val = count;
    valid_at = vat;
    exp_code_v = model_code(count);
    base = (32'd1024 << 8) | (32'(ch) << 1);
    reads = (vat == 0 || vat > MAX_READS) ? MAX_READS : vat;
    exp_q.push_back(mk(1, 2'd1, 32'd1));
    exp_q.push_back(mk(1, 2'd0, base));
    exp_q.push_back(mk(1, 2'd0, base | 32'd1));
    for (int i = 0; i < reads; i++) exp_q.push_back(mk(0, 2'd1, 0));
    exp_q.push_back(mk(0, 2'd2, 0));
    exp_q.push_back(mk(1, 2'd0, base));
    exp_q.push_back(mk(1, 2'd1, 32'd0));
    done_seen = 0;
    @(negedge clk);
    chan_i = 2'(ch);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check(osc_en_o && slew_code_o == 3'd4, "R2", "osc on and code preload",
          {osc_en_o, slew_code_o}, {1'b1, 3'd4});
    if (busy_start) begin
      repeat (100) @(negedge clk);
      chan_i = 2'(ch + 1);
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
    end
    t0 = 0;
    while (done_seen == 0 && t0 < 9000) begin
      @(negedge clk);
      t0++;
    end
    check(done_seen == 1, "R9", "done reached", done_seen, 1);
    repeat (60) @(negedge clk);
    check(!osc_en_o && done_seen == 1, "R10", "idle after single done",
          {osc_en_o, 8'(done_seen)}, {1'b0, 8'd1});
  endtask

  initial begin
    rst_n = 1'b0; start_i = 1'b0; chan_i = '0;
    cnt_val = 0; valid_at = 0; aux_rd_n = 0; rd_q = '0;
    prev_osc = 1'b0; prev_code = 3'd0; first_acc = 0; last_aux_cyc = -1;
    osc_rise_cyc = 0; done_seen = 0; exp_code_v = 4;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(slew_code_o == 3'd4, "R1", "reset code", slew_code_o, 4);
    check(!osc_en_o, "R1", "reset osc", osc_en_o, 0);
    check(!done_o, "R1", "reset done", done_o, 0);
    check(!mtr_req_o, "R1", "reset meter idle", mtr_req_o, 0);

    run_cal(0, 1024, 1, 0);        // R7 code 1
    run_cal(1, 0, 2, 0);           // R8 default 4
    run_cal(2, 100, 3, 0);         // R7 code 7
    run_cal(3, 1, 1, 0);           // R7 truncated to low 3 bits
    run_cal(0, 497, 2, 0);         // R7 rounding below half
    run_cal(1, 496, 1, 0);         // R7 rounding above half
    run_cal(2, 16777215, 1, 0);    // R7 code 0
    run_cal(1, 300, 0, 0);         // R5 timeout, never valid
    run_cal(3, 182, 21, 0);        // R4 valid on the last read
    run_cal(2, 150, 2, 1);         // R10 start while busy

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule